// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This combinational block sits in front of the ALU of a five-stage in-order integer pipeline. For the instruction now in execute, it decides where each of the two ALU operands comes from. There are three possible sources: the value read from the register file during decode, the result waiting in the EX/MEM latch, or the result waiting in the MEM/WB latch. The block drives a 2-bit select for each operand and also drives the muxed operand value, so the ALU can take the operands directly.

A separate output flags a load-use hazard. This happens when the instruction in execute is a load and the instruction in decode reads that load's destination. Surrounding control logic uses this flag to freeze the PC and the IF/ID latch and to put a bubble into ID/EX for one cycle. A register that is written back in the same cycle it is read in decode needs nothing from this block, because the register file writes before it reads. By default, register index 0 is hard-wired to zero and never takes part in forwarding or stalls.

Top module: `operand_forward_unit`

## Requirements
- R1: `fwd_sel_a` is 1 (EX/MEM) when `exm_wr_en` is high and `exm_dst` equals `ex_src_a`, provided `exm_dst` is not 0.
- R2: `fwd_sel_b` is 1 under the same condition, with `ex_src_b` as the compared source.
- R3: A select is 2 (MEM/WB) when `mwb_wr_en` is high, `mwb_dst` equals that source, `mwb_dst` is not 0, and the EX/MEM condition of R1/R2 does not hold.
- R4: When EX/MEM and MEM/WB both write the same source register, the select is 1, because the younger result wins.
- R5: With no qualifying match, the select is 0 and the operand is the register-file value. A destination match whose write flag is low counts as no match.
- R6: A destination index of 0 never forwards from either stage, even when its write flag is high.
- R7: `opnd_a` and `opnd_b` equal `ex_rf_a`/`ex_rf_b`, `exm_result`, or `mwb_result` for selects 0, 1 and 2 respectively. Select value 3 never appears.
- R8: `load_use_stall` is 1 when `ex_is_load` is high and a nonzero `ex_dst` equals `id_src_a` or `id_src_b`.
- R9: `load_use_stall` is 0 when `ex_is_load` is low, when `ex_dst` is 0, or when neither decode source matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register index of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register index of the execute-stage instruction |
| ex_rf_a | input | 32 | First operand as read from the register file at decode |
| ex_rf_b | input | 32 | Second operand as read from the register file at decode |
| exm_dst | input | 5 | Destination index held in the EX/MEM latch |
| exm_wr_en | input | 1 | EX/MEM instruction writes a register |
| exm_result | input | 32 | Result held in the EX/MEM latch |
| mwb_dst | input | 5 | Destination index held in the MEM/WB latch |
| mwb_wr_en | input | 1 | MEM/WB instruction writes a register |
| mwb_result | input | 32 | Result held in the MEM/WB latch |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | 5 | Destination index of the execute-stage instruction |
| id_src_a | input | 5 | First source index of the decode-stage instruction |
| id_src_b | input | 5 | Second source index of the decode-stage instruction |
| fwd_sel_a | output | 2 | Operand A source: 0 register file, 1 EX/MEM, 2 MEM/WB |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |
| load_use_stall | output | 1 | Load-use hazard, one stall cycle needed |

## Verification
The two functions that can land in the same cycle are the two forwarding paths competing for one source register, and forwarding together with a load-use stall. To provoke the first, the bench writes the same nonzero index into both latches while an operand reads it, then clears each write flag in turn. It judges the result by which latch value reaches the operand. To provoke the second, the bench pairs an EX/MEM forward with a load in execute whose destination matches a decode source. It checks that the stall flag and both selects are correct together, without either one disturbing the other.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
   // Operand source encoding; the ALU input mux decodes these values.
   typedef enum logic [1:0] {
      SRC_RF    = 2'd0,
      SRC_EXMEM = 2'd1,
      SRC_MEMWB = 2'd2
   } opnd_src_e;

   localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned REG_IDX_W      = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_IDX_W-1:0] src_idx,
   input  logic [REG_IDX_W-1:0] exm_dst,
   input  logic                 exm_wr_en,
   input  logic [REG_IDX_W-1:0] mwb_dst,
   input  logic                 mwb_wr_en,
   output opfwd_pkg::opnd_src_e sel
);
   import opfwd_pkg::*;

   logic exm_hit;
   logic mwb_hit;

   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         // Index 0 reads as constant zero, so no stage may forward into it.
         assign exm_hit = exm_wr_en && (exm_dst != '0) && (exm_dst == src_idx);
         assign mwb_hit = mwb_wr_en && (mwb_dst != '0) && (mwb_dst == src_idx);
      end else begin : g_zero_plain
         assign exm_hit = exm_wr_en && (exm_dst == src_idx);
         assign mwb_hit = mwb_wr_en && (mwb_dst == src_idx);
      end
   endgenerate

   // Younger result has strict priority over the older one.
   always_comb begin
      if (exm_hit)      sel = SRC_EXMEM;
      else if (mwb_hit) sel = SRC_MEMWB;
      else              sel = SRC_RF;
   end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux #(
   parameter int unsigned DATA_W = 32
) (
   input  opfwd_pkg::opnd_src_e sel,
   input  logic [DATA_W-1:0]    rf_val,
   input  logic [DATA_W-1:0]    exm_val,
   input  logic [DATA_W-1:0]    mwb_val,
   output logic [DATA_W-1:0]    opnd
);
   import opfwd_pkg::*;

   always_comb begin
      unique case (sel)
         SRC_EXMEM: opnd = exm_val;
         SRC_MEMWB: opnd = mwb_val;
         default:   opnd = rf_val;
      endcase
   end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
   parameter int unsigned REG_IDX_W      = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic                 ex_is_load,
   input  logic [REG_IDX_W-1:0] ex_dst,
   input  logic [REG_IDX_W-1:0] id_src_a,
   input  logic [REG_IDX_W-1:0] id_src_b,
   output logic                 stall
);
   logic dst_live;
   logic src_match;

   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         assign dst_live = (ex_dst != '0);
      end else begin : g_zero_plain
         assign dst_live = 1'b1;
      end
   endgenerate

   assign src_match = (ex_dst == id_src_a) || (ex_dst == id_src_b);
   assign stall     = ex_is_load && dst_live && src_match;
endmodule

// File: rtl/operand_forward_unit.sv
module operand_forward_unit #(
   parameter int unsigned REG_IDX_W      = 5,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_IDX_W-1:0] ex_src_a,
   input  logic [REG_IDX_W-1:0] ex_src_b,
   input  logic [DATA_W-1:0]    ex_rf_a,
   input  logic [DATA_W-1:0]    ex_rf_b,
   input  logic [REG_IDX_W-1:0] exm_dst,
   input  logic                 exm_wr_en,
   input  logic [DATA_W-1:0]    exm_result,
   input  logic [REG_IDX_W-1:0] mwb_dst,
   input  logic                 mwb_wr_en,
   input  logic [DATA_W-1:0]    mwb_result,
   input  logic                 ex_is_load,
   input  logic [REG_IDX_W-1:0] ex_dst,
   input  logic [REG_IDX_W-1:0] id_src_a,
   input  logic [REG_IDX_W-1:0] id_src_b,
   output logic [1:0]           fwd_sel_a,
   output logic [1:0]           fwd_sel_b,
   output logic [DATA_W-1:0]    opnd_a,
   output logic [DATA_W-1:0]    opnd_b,
   output logic                 load_use_stall
);
   import opfwd_pkg::*;

   localparam int unsigned NREG = 1 << REG_IDX_W;

   generate
      if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_idx_w
         $error("operand_forward_unit: REG_IDX_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("operand_forward_unit: DATA_W must be positive");
      end
      if (NREG < 2) begin : g_bad_nreg
         $error("operand_forward_unit: register file too small");
      end
   endgenerate

   logic [REG_IDX_W-1:0] src_idx [NUM_OPND];
   logic [DATA_W-1:0]    rf_val  [NUM_OPND];
   opnd_src_e            sel     [NUM_OPND];
   logic [DATA_W-1:0]    opnd    [NUM_OPND];

   assign src_idx[0] = ex_src_a;
   assign src_idx[1] = ex_src_b;
   assign rf_val[0]  = ex_rf_a;
   assign rf_val[1]  = ex_rf_b;

   generate
      for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
         fwd_match #(
            .REG_IDX_W      (REG_IDX_W),
            .ZERO_REG_FIXED (ZERO_REG_FIXED)
         ) u_match (
            .src_idx   (src_idx[i]),
            .exm_dst   (exm_dst),
            .exm_wr_en (exm_wr_en),
            .mwb_dst   (mwb_dst),
            .mwb_wr_en (mwb_wr_en),
            .sel       (sel[i])
         );

         fwd_mux #(
            .DATA_W (DATA_W)
         ) u_mux (
            .sel     (sel[i]),
            .rf_val  (rf_val[i]),
            .exm_val (exm_result),
            .mwb_val (mwb_result),
            .opnd    (opnd[i])
         );
      end
   endgenerate

   assign fwd_sel_a = sel[0];
   assign fwd_sel_b = sel[1];
   assign opnd_a    = opnd[0];
   assign opnd_b    = opnd[1];

   load_use_detect #(
      .REG_IDX_W      (REG_IDX_W),
      .ZERO_REG_FIXED (ZERO_REG_FIXED)
   ) u_load_use (
      .ex_is_load (ex_is_load),
      .ex_dst     (ex_dst),
      .id_src_a   (id_src_a),
      .id_src_b   (id_src_b),
      .stall      (load_use_stall)
   );
endmodule

// File: rtl/opfwd_checker.sv
module opfwd_checker #(
   parameter int unsigned REG_IDX_W      = 5,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input logic [REG_IDX_W-1:0] ex_src_a,
   input logic [REG_IDX_W-1:0] ex_src_b,
   input logic [DATA_W-1:0]    ex_rf_a,
   input logic [DATA_W-1:0]    ex_rf_b,
   input logic [REG_IDX_W-1:0] exm_dst,
   input logic                 exm_wr_en,
   input logic [DATA_W-1:0]    exm_result,
   input logic [REG_IDX_W-1:0] mwb_dst,
   input logic                 mwb_wr_en,
   input logic [DATA_W-1:0]    mwb_result,
   input logic                 ex_is_load,
   input logic [REG_IDX_W-1:0] ex_dst,
   input logic [REG_IDX_W-1:0] id_src_a,
   input logic [REG_IDX_W-1:0] id_src_b,
   input logic [1:0]           fwd_sel_a,
   input logic [1:0]           fwd_sel_b,
   input logic [DATA_W-1:0]    opnd_a,
   input logic [DATA_W-1:0]    opnd_b,
   input logic                 load_use_stall
);
   logic zero_ok_e, zero_ok_w, zero_ok_x;
   assign zero_ok_e = !ZERO_REG_FIXED || (exm_dst != '0);
   assign zero_ok_w = !ZERO_REG_FIXED || (mwb_dst != '0);
   assign zero_ok_x = !ZERO_REG_FIXED || (ex_dst  != '0);

   always_comb begin
      // R1: a live EX/MEM writer of source A forces select 1
      p_exm_fwd_a_r1: assert (!(exm_wr_en && zero_ok_e && exm_dst == ex_src_a) || fwd_sel_a == 2'd1)
         else $error("p_exm_fwd_a_r1");
      // R2
      p_exm_fwd_b_r2: assert (!(exm_wr_en && zero_ok_e && exm_dst == ex_src_b) || fwd_sel_b == 2'd1)
         else $error("p_exm_fwd_b_r2");
      // R3: select 2 only with a live MEM/WB writer of that source
      p_mwb_only_r3: assert (fwd_sel_a != 2'd2 || (mwb_wr_en && zero_ok_w && mwb_dst == ex_src_a))
         else $error("p_mwb_only_r3");
      // R4: select 2 never coexists with a qualifying EX/MEM match
      p_younger_wins_r4: assert (fwd_sel_b != 2'd2 || !(exm_wr_en && zero_ok_e && exm_dst == ex_src_b))
         else $error("p_younger_wins_r4");
      // R7: operand values follow the select; select 3 is never produced
      p_opnd_a_r7: assert ((fwd_sel_a == 2'd0 && opnd_a == ex_rf_a) ||
                           (fwd_sel_a == 2'd1 && opnd_a == exm_result) ||
                           (fwd_sel_a == 2'd2 && opnd_a == mwb_result))
         else $error("p_opnd_a_r7");
      p_opnd_b_r7: assert ((fwd_sel_b == 2'd0 && opnd_b == ex_rf_b) ||
                           (fwd_sel_b == 2'd1 && opnd_b == exm_result) ||
                           (fwd_sel_b == 2'd2 && opnd_b == mwb_result))
         else $error("p_opnd_b_r7");
      // R8, R9: stall exactly on a live load destination read in decode
      p_stall_r8: assert (load_use_stall == (ex_is_load && zero_ok_x &&
                          (ex_dst == id_src_a || ex_dst == id_src_b)))
         else $error("p_stall_r8");
   end
endmodule

bind operand_forward_unit opfwd_checker #(
   .REG_IDX_W      (REG_IDX_W),
   .DATA_W         (DATA_W),
   .ZERO_REG_FIXED (ZERO_REG_FIXED)
) u_opfwd_checker (.*);

// File: tb/operand_forward_unit_test.sv
module operand_forward_unit_test;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [31:0] RF_A = 32'h1111_0001;
   localparam logic [31:0] RF_B = 32'h2222_0002;
   localparam logic [31:0] EXM  = 32'hAAAA_0003;
   localparam logic [31:0] MWB  = 32'hBBBB_0004;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [4:0]  ex_src_a, ex_src_b, exm_dst, mwb_dst, ex_dst, id_src_a, id_src_b;
   logic [31:0] ex_rf_a, ex_rf_b, exm_result, mwb_result, opnd_a, opnd_b;
   logic        exm_wr_en, mwb_wr_en, ex_is_load, load_use_stall;
   logic [1:0]  fwd_sel_a, fwd_sel_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   operand_forward_unit uut (
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
      .exm_dst(exm_dst), .exm_wr_en(exm_wr_en), .exm_result(exm_result),
      .mwb_dst(mwb_dst), .mwb_wr_en(mwb_wr_en), .mwb_result(mwb_result),
      .ex_is_load(ex_is_load), .ex_dst(ex_dst), .id_src_a(id_src_a), .id_src_b(id_src_b),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .load_use_stall(load_use_stall)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      ex_src_a = 5'd0; ex_src_b = 5'd0; ex_rf_a = RF_A; ex_rf_b = RF_B;
      exm_dst = 5'd0; exm_wr_en = 1'b0; exm_result = EXM;
      mwb_dst = 5'd0; mwb_wr_en = 1'b0; mwb_result = MWB;
      ex_is_load = 1'b0; ex_dst = 5'd0; id_src_a = 5'd0; id_src_b = 5'd0;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic t_reset_state();
      idle(); settle();
      chk("R5 sel_a idle", {30'd0, fwd_sel_a}, 32'd0);
      chk("R5 sel_b idle", {30'd0, fwd_sel_b}, 32'd0);
      chk("R5 opnd_a idle", opnd_a, RF_A);
      chk("R9 stall idle", {31'd0, load_use_stall}, 32'd0);
   endtask

   task automatic t_exmem_path();
      idle(); ex_src_a = 5'd3; ex_src_b = 5'd7; exm_dst = 5'd3; exm_wr_en = 1'b1; settle();
      chk("R1 sel_a exm", {30'd0, fwd_sel_a}, 32'd1);
      chk("R7 opnd_a exm", opnd_a, EXM);
      chk("R5 sel_b untouched", {30'd0, fwd_sel_b}, 32'd0);
      chk("R7 opnd_b rf", opnd_b, RF_B);
      exm_dst = 5'd7; settle();
      chk("R2 sel_b exm", {30'd0, fwd_sel_b}, 32'd1);
      chk("R7 opnd_b exm", opnd_b, EXM);
      chk("R5 sel_a now rf", {30'd0, fwd_sel_a}, 32'd0);
   endtask

   task automatic t_memwb_path();
      idle(); ex_src_a = 5'd12; ex_src_b = 5'd31; mwb_dst = 5'd31; mwb_wr_en = 1'b1; settle();
      chk("R3 sel_b mwb", {30'd0, fwd_sel_b}, 32'd2);
      chk("R7 opnd_b mwb", opnd_b, MWB);
      mwb_dst = 5'd12; settle();
      chk("R3 sel_a mwb", {30'd0, fwd_sel_a}, 32'd2);
      chk("R7 opnd_a mwb", opnd_a, MWB);
   endtask

   task automatic t_priority();
      idle(); ex_src_a = 5'd5; ex_src_b = 5'd5;
      exm_dst = 5'd5; exm_wr_en = 1'b1; mwb_dst = 5'd5; mwb_wr_en = 1'b1; settle();
      chk("R4 sel_a younger", {30'd0, fwd_sel_a}, 32'd1);
      chk("R4 sel_b younger", {30'd0, fwd_sel_b}, 32'd1);
      chk("R4 opnd_a younger", opnd_a, EXM);
      exm_wr_en = 1'b0; settle();
      chk("R3 sel_a older after exm off", {30'd0, fwd_sel_a}, 32'd2);
      exm_wr_en = 1'b1; exm_dst = 5'd6; settle();
      chk("R3 sel_a older with other exm dst", {30'd0, fwd_sel_a}, 32'd2);
      mwb_wr_en = 1'b0; settle();
      chk("R5 sel_a no live writer", {30'd0, fwd_sel_a}, 32'd0);
      chk("R5 opnd_a rf", opnd_a, RF_A);
   endtask

   task automatic t_write_gate();
      idle(); ex_src_a = 5'd9; ex_src_b = 5'd10; exm_dst = 5'd9; mwb_dst = 5'd10; settle();
      chk("R5 sel_a wr low", {30'd0, fwd_sel_a}, 32'd0);
      chk("R5 sel_b wr low", {30'd0, fwd_sel_b}, 32'd0);
      chk("R5 opnd_b wr low", opnd_b, RF_B);
   endtask

   task automatic t_zero_reg();
      idle(); ex_src_a = 5'd0; ex_src_b = 5'd0;
      exm_dst = 5'd0; exm_wr_en = 1'b1; mwb_dst = 5'd0; mwb_wr_en = 1'b1; settle();
      chk("R6 sel_a r0", {30'd0, fwd_sel_a}, 32'd0);
      chk("R6 sel_b r0", {30'd0, fwd_sel_b}, 32'd0);
      chk("R6 opnd_a r0", opnd_a, RF_A);
      exm_wr_en = 1'b0; settle();
      chk("R6 sel_b r0 mwb only", {30'd0, fwd_sel_b}, 32'd0);
   endtask

   task automatic t_load_use();
      idle(); ex_is_load = 1'b1; ex_dst = 5'd4; id_src_a = 5'd1; id_src_b = 5'd4;
      ex_src_a = 5'd8; exm_dst = 5'd8; exm_wr_en = 1'b1; settle();
      chk("R8 stall on src_b", {31'd0, load_use_stall}, 32'd1);
      chk("R1 sel_a beside stall", {30'd0, fwd_sel_a}, 32'd1);
      id_src_a = 5'd4; id_src_b = 5'd2; settle();
      chk("R8 stall on src_a", {31'd0, load_use_stall}, 32'd1);
      ex_is_load = 1'b0; settle();
      chk("R9 no stall non-load", {31'd0, load_use_stall}, 32'd0);
      ex_is_load = 1'b1; id_src_a = 5'd3; settle();
      chk("R9 no stall no match", {31'd0, load_use_stall}, 32'd0);
      ex_dst = 5'd0; id_src_a = 5'd0; id_src_b = 5'd0; settle();
      chk("R9 no stall r0 load", {31'd0, load_use_stall}, 32'd0);
   endtask

   initial begin
      idle();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_exmem_path();
      t_memwb_path();
      t_priority();
      t_write_gate();
      t_zero_reg();
      t_load_use();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule